// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-programmed master for the two-wire management interface of Ethernet PHYs. It generates the management clock (MDC) from the system clock and serialises management frames onto the data line (MDIO). It also controls the line's output enable and shifts in the 16-bit value a PHY returns during a read. Software reaches it through a small synchronous register port with a write strobe, a byte offset, write data and a read-data mux that follows the offset without delay.

To run a transaction, software loads the PHY and register addresses, and also loads the data word for a write or address frame. It then writes the operation code to the command register. That write starts the frame and raises a busy flag. Software polls the flag until it clears, then reads back the captured data and the sticky error bit.

There are two addressing styles. In direct mode the register address travels inside the read or write frame. In indirect mode an address frame comes first and sets the target, and the read or write that follows refers to it. The preamble can be left out to save 32 bit times.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register reads 0x9000, the divider reads DIV_INIT (4), and the command, address, data and status registers read 0. MDC and the output enable are low.
- R2: The register offsets are 0x00 control, 0x04 divider, 0x10 command, 0x14 address and 0x18 data, with status at 0x1C. The address register keeps mode in bit 14, PHY in bits 12:8 and register in bits 4:0. The divider keeps bits 9:0. Bits that are not implemented read 0.
- R3: A write to the command register starts a frame when the block is enabled and idle. The operation is taken from bits 9:8: 0 for an address frame, 1 for a write, 2 for a read. Command bit 15 reads 1 for the whole frame. Operation 3 starts nothing and is not stored.
- R4: Every frame begins with 32 one bits, unless command bit 0 is set. In that case the frame begins directly with the start field, and the total is 32 bits instead of 64.
- R5: The frame fields go out MSB first: start (2), opcode (2), PHY (5), register (5), turnaround (2), data (16). In direct mode a read uses start 01 and opcode 10, and a write uses start 01 and opcode 01. An address frame uses start 00 and opcode 00. In indirect mode a read uses start 00 and opcode 11, and a write uses start 00 and opcode 01. For writes and address frames the master sends turnaround 10 followed by the data register.
- R6: MDC is low when idle. Each bit time holds MDC low for divider+1 clocks and then high for divider+1 clocks. Busy clears at the falling MDC edge that ends the last bit, 2*(divider+1)*bits clocks after the command write.
- R7: The master changes MDIO only when MDC falls, so the line is stable while MDC is high. MDIO input is sampled as MDC rises.
- R8: During a read the output enable is low for the 2 turnaround bits and the 16 data bits. The 16 bits sampled during the data phase are in the data register when busy clears.
- R9: If the second turnaround bit of a read is sampled high, status bit 1 is set. The bit stays set through later good frames. Only writing 1 to status bit 1 clears it.
- R10: A command write while busy is set is ignored. The running frame is not altered, and the stored operation and suppression bits keep their values.
- R11: The block is enabled only when control bit 15 is 0 and bit 12 is 1. When it is not enabled, command writes start nothing. Setting bit 15 during a frame ends it on the next clock, with busy, MDC and the output enable all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, high when the master drives |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The hardest situations to reach from the ports depend on timing relative to a running frame. One is a command write that lands in the middle of a frame. Another is a PHY that fails to pull the second turnaround bit low. A third is a hold request that cuts a frame short.

The bench's PHY responder counts MDC rising edges and decides each returned bit from that count. This lets it drive a high turnaround on demand, or return an arbitrary 16-bit pattern. Mid-frame command and control writes are issued a fixed number of clocks after a start, well inside the frame. Afterwards the captured bit stream and the register readback show whether anything was disturbed.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W    = 10,
  parameter int DIV_INIT = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRM_LEN = 32;
  localparam int TOT_LEN = PRE_LEN + FRM_LEN;
  localparam int RW      = $clog2(TOT_LEN + 1);
  localparam logic [RW-1:0] R_ONE  = RW'(1);
  localparam logic [RW-1:0] R_DATA = RW'(16);
  localparam logic [RW-1:0] R_TA2  = RW'(17);
  localparam logic [RW-1:0] R_REL  = RW'(18);
  localparam logic [4:0] A_CTL = 5'h00, A_DIV = 5'h04, A_CMD = 5'h10;
  localparam logic [4:0] A_ADR = 5'h14, A_DAT = 5'h18, A_STS = 5'h1C;
  localparam logic [1:0] OP_ADR = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_RSV = 2'd3;

  logic             hold, sel_mdio, sup, mode, busy, err;
  logic [1:0]       op;
  logic [DIV_W-1:0] div, hc;
  logic [4:0]       phy, regn;
  logic [15:0]      dat;
  logic [TOT_LEN-1:0] sh;
  logic [RW-1:0]    rem;

  logic en, go, is_rd, tick, rise;
  logic [1:0] nop, f_st, f_op, f_ta;
  logic [15:0] f_dat;
  logic [FRM_LEN-1:0] frm;

  assign en    = !hold && sel_mdio;
  assign nop   = reg_wdata[9:8];
  assign go    = reg_wr && reg_addr == A_CMD && !busy && en && nop != OP_RSV;
  assign is_rd = op == OP_RD;
  assign tick  = busy && hc == div;
  assign rise  = tick && !mdc;

  assign f_st  = (nop == OP_ADR || !mode) ? 2'b00 : 2'b01;
  assign f_op  = (nop == OP_ADR) ? 2'b00 : (nop == OP_WR) ? 2'b01 : (mode ? 2'b10 : 2'b11);
  assign f_ta  = (nop == OP_RD) ? 2'b11 : 2'b10;
  assign f_dat = (nop == OP_RD) ? 16'hFFFF : dat;
  assign frm   = {f_st, f_op, phy, regn, f_ta, f_dat};

  assign mdio_o  = busy ? sh[TOT_LEN-1] : 1'b1;
  assign mdio_oe = busy && !(is_rd && rem <= R_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      mdc  <= 1'b0;
      hc   <= '0;
      sh   <= '1;
      rem  <= '0;
    end else if (hold) begin
      busy <= 1'b0;
      mdc  <= 1'b0;
      hc   <= '0;
    end else if (go) begin
      busy <= 1'b1;
      mdc  <= 1'b0;
      hc   <= '0;
      if (reg_wdata[0]) begin
        sh  <= {frm, {PRE_LEN{1'b1}}};
        rem <= RW'(FRM_LEN);
      end else begin
        sh  <= {{PRE_LEN{1'b1}}, frm};
        rem <= RW'(TOT_LEN);
      end
    end else if (busy) begin
      if (tick) begin
        hc  <= '0;
        mdc <= !mdc;
        if (mdc) begin
          if (rem == R_ONE) busy <= 1'b0;
          sh  <= {sh[TOT_LEN-2:0], 1'b1};
          rem <= rem - R_ONE;
        end
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= 1'b1;
      sel_mdio <= 1'b1;
      div      <= DIV_W'(DIV_INIT);
      op       <= 2'd0;
      sup      <= 1'b0;
      mode     <= 1'b0;
      phy      <= '0;
      regn     <= '0;
      dat      <= '0;
      err      <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTL) begin
        hold     <= reg_wdata[15];
        sel_mdio <= reg_wdata[12];
      end
      if (reg_wr && reg_addr == A_DIV) div <= reg_wdata[DIV_W-1:0];
      if (go) begin
        op  <= nop;
        sup <= reg_wdata[0];
      end
      if (reg_wr && reg_addr == A_ADR) begin
        mode <= reg_wdata[14];
        phy  <= reg_wdata[12:8];
        regn <= reg_wdata[4:0];
      end
      if (reg_wr && reg_addr == A_DAT) dat <= reg_wdata;
      if (rise && is_rd && rem <= R_DATA) dat <= {dat[14:0], mdio_i};
      if (reg_wr && reg_addr == A_STS && reg_wdata[1]) err <= 1'b0;
      if (rise && is_rd && rem == R_TA2 && mdio_i) err <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = {hold, 2'b00, sel_mdio, 12'h000};
      A_DIV:   reg_rdata = {{(16-DIV_W){1'b0}}, div};
      A_CMD:   reg_rdata = {busy, 5'b00000, op, 7'b0000000, sup};
      A_ADR:   reg_rdata = {1'b0, mode, 1'b0, phy, 3'b000, regn};
      A_DAT:   reg_rdata = dat;
      A_STS:   reg_rdata = {14'h0000, err, 1'b0};
      default: reg_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic hold,
  input logic busy,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  // R6
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R6
  end_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(hold) |-> $fell(mdc));

  // R7
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$fell(mdc) |-> $stable(mdio_o));

  // R8
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$fell(mdc) |-> $stable(mdio_oe));

  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .busy(busy),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam logic [4:0] A_CTL = 5'h00, A_DIV = 5'h04, A_CMD = 5'h10;
  localparam logic [4:0] A_ADR = 5'h14, A_DAT = 5'h18, A_STS = 5'h1C;
  // {op[45:44], mode[43], sup[42], phy[41:37], reg[36:32], wdata[31:16], reply[15:0]}
  localparam logic [45:0] VEC [7] = '{
    {2'd2, 1'b1, 1'b0, 5'h01, 5'h02, 16'h0000, 16'hBEEF},
    {2'd1, 1'b1, 1'b0, 5'h03, 5'h1C, 16'hA55A, 16'h0000},
    {2'd0, 1'b0, 1'b0, 5'h11, 5'h05, 16'h8001, 16'h0000},
    {2'd2, 1'b0, 1'b0, 5'h07, 5'h03, 16'h0000, 16'h1357},
    {2'd1, 1'b0, 1'b1, 5'h1E, 5'h0A, 16'h0F0F, 16'h0000},
    {2'd2, 1'b1, 1'b1, 5'h1F, 5'h1F, 16'h0000, 16'h0000},
    {2'd1, 1'b1, 1'b1, 5'h00, 5'h00, 16'hFFFF, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, mdio_i;
  logic [4:0] reg_addr = 5'h00;
  logic [15:0] reg_wdata = 16'h0000, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int n_chk = 0, n_bad = 0;

  logic rsp_clr = 1'b0, ta_bit = 1'b0;
  int pre = 32, nrise;
  logic [15:0] rsp = 16'h0000;
  logic [63:0] cap_o, cap_oe;

  always #5 clk = ~clk;

  mdio_master u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  function automatic logic rbit(int k);
    int f = k - pre;
    if (f == 15) return ta_bit;
    if (f >= 16 && f <= 31) return rsp[31-f];
    return 1'b1;
  endfunction

  always @(posedge mdc or posedge rsp_clr)
    if (rsp_clr) begin
      nrise <= 0; cap_o <= '0; cap_oe <= '0;
    end else begin
      if (nrise < 64) begin
        cap_o[63-nrise]  <= mdio_o;
        cap_oe[63-nrise] <= mdio_oe;
      end
      nrise <= nrise + 1;
    end

  always @(negedge mdc or posedge rsp_clr)
    if (rsp_clr) mdio_i <= 1'b1;
    else mdio_i <= rbit(nrise);

  task automatic chk(string tag, logic [63:0] a, logic [63:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, a, e);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    reg_addr = A_CMD;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); #1;
      if (!reg_rdata[15]) return;
    end
    chk("R3 busy never cleared", 64'(1), 64'(0));
  endtask

  task automatic arm(logic s, logic t, logic [15:0] r);
    pre = s ? 0 : 32; ta_bit = t; rsp = r;
    #1 rsp_clr = 1'b1; #1 rsp_clr = 1'b0;
  endtask

  task automatic start(logic [1:0] op, logic m, logic s, logic [4:0] p, logic [4:0] r,
                       logic [15:0] wd, logic [15:0] rr, logic t);
    arm(s, t, rr);
    wr(A_ADR, {1'b0, m, 1'b0, p, 3'b000, r});
    wr(A_DAT, wd);
    wr(A_CMD, {6'b0, op, 7'b0, s});
  endtask

  task automatic check_frame(string tag, logic [1:0] op, logic m, logic s, logic [4:0] p,
                             logic [4:0] r, logic [15:0] wd, logic [15:0] rr);
    logic [1:0] st, oc, ta;
    logic [31:0] frm;
    logic [63:0] eo, eoe;
    logic [15:0] v;
    int n = s ? 32 : 64;
    st = (op == 2'd0 || !m) ? 2'b00 : 2'b01;
    oc = (op == 2'd0) ? 2'b00 : (op == 2'd1) ? 2'b01 : (m ? 2'b10 : 2'b11);
    ta = (op == 2'd2) ? 2'b00 : 2'b10;
    frm = {st, oc, p, r, ta, (op == 2'd2) ? 16'h0000 : wd};
    eo  = s ? {frm, 32'h0} : {32'hFFFF_FFFF, frm};
    eoe = 64'hFFFF_FFFF_FFFF_FFFF << (64 - n);
    if (op == 2'd2) eoe = eoe & ~(64'h3FFFF << (64 - n));
    chk({tag, " R4 bit count"}, 64'(nrise), 64'(n));
    chk({tag, " R8 output enable"}, cap_oe, eoe);
    chk({tag, " R5 frame bits"}, cap_o & cap_oe, eo & eoe);
    if (op == 2'd2) begin
      rd(A_DAT, v);
      chk({tag, " R8 read data"}, 64'(v), 64'(rr));
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R3 run did not finish actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    realtime t1, t2, t3;
    logic o1;
    int k;
    arm(1'b0, 1'b0, 16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTL, v); chk("R1 control", 64'(v), 64'h9000);
    rd(A_DIV, v); chk("R1 divider", 64'(v), 64'h0004);
    rd(A_CMD, v); chk("R1 command", 64'(v), 64'h0000);
    rd(A_ADR, v); chk("R1 address", 64'(v), 64'h0000);
    rd(A_DAT, v); chk("R1 data", 64'(v), 64'h0000);
    rd(A_STS, v); chk("R1 status", 64'(v), 64'h0000);
    chk("R1 mdc and oe", 64'({mdc, mdio_oe}), 64'(0));

    // R11 held in reset: command ignored
    wr(A_CMD, 16'h0200);
    repeat (40) @(negedge clk);
    rd(A_CMD, v); chk("R11 no start while held", 64'(v), 64'h0000);
    chk("R11 no mdc while held", 64'(nrise), 64'(0));
    wr(A_CTL, 16'h1000);
    rd(A_CTL, v); chk("R2 control readback", 64'(v), 64'h1000);

    // R2 field readback
    wr(A_ADR, 16'hFFFF); rd(A_ADR, v); chk("R2 address fields", 64'(v), 64'h5F1F);
    wr(A_DIV, 16'hFFFF); rd(A_DIV, v); chk("R2 divider width", 64'(v), 64'h03FF);
    wr(A_DAT, 16'hC3A5); rd(A_DAT, v); chk("R2 data", 64'(v), 64'hC3A5);
    wr(A_DIV, 16'h0001);

    // R4 R5 R8 vector table
    foreach (VEC[i]) begin
      start(VEC[i][45:44], VEC[i][43], VEC[i][42], VEC[i][41:37], VEC[i][36:32],
            VEC[i][31:16], VEC[i][15:0], 1'b0);
      wait_idle();
      check_frame($sformatf("vec%0d", i), VEC[i][45:44], VEC[i][43], VEC[i][42],
                  VEC[i][41:37], VEC[i][36:32], VEC[i][31:16], VEC[i][15:0]);
      rd(A_CMD, v);
      chk("R3 command readback", 64'(v), 64'({VEC[i][45:44], 7'b0, VEC[i][42]}));
    end
    rd(A_STS, v); chk("R9 no error on good reads", 64'(v), 64'h0000);

    // R3 reserved operation
    arm(1'b0, 1'b0, 16'h0);
    wr(A_CMD, 16'h0300);
    repeat (40) @(negedge clk);
    rd(A_CMD, v); chk("R3 operation 3 ignored", 64'(v), 64'h0101);
    chk("R3 operation 3 no mdc", 64'(nrise), 64'(0));

    // R6 frame duration with divider 3, suppressed preamble
    wr(A_DIV, 16'h0003);
    arm(1'b1, 1'b0, 16'h0);
    wr(A_ADR, 16'h4102);
    wr(A_CMD, 16'h0101);
    reg_addr = A_CMD; #1;
    k = 0;
    while (reg_rdata[15] && k < 5000) begin
      @(negedge clk); #1; k++;
    end
    chk("R6 frame duration", 64'(k), 64'(256));
    chk("R6 mdc low when idle", 64'(mdc), 64'(0));

    // R6 R7 MDC shape and stable data while high
    start(2'd1, 1'b1, 1'b0, 5'h05, 5'h06, 16'h5AA5, 16'h0, 1'b0);
    @(posedge mdc); t1 = $realtime; o1 = mdio_o;
    @(negedge clk); #1;
    chk("R7 mdio stable while mdc high", 64'(mdio_o), 64'(o1));
    @(negedge mdc); t2 = $realtime;
    @(posedge mdc); t3 = $realtime;
    chk("R6 mdc high time", 64'(int'(t2 - t1)), 64'(40));
    chk("R6 mdc period", 64'(int'(t3 - t1)), 64'(80));
    wait_idle();
    wr(A_DIV, 16'h0001);

    // R10 command write while busy
    start(2'd1, 1'b1, 1'b0, 5'h09, 5'h0C, 16'h1234, 16'h0, 1'b0);
    repeat (20) @(negedge clk);
    wr(A_CMD, 16'h0201);
    wait_idle();
    check_frame("R10 busy write", 2'd1, 1'b1, 1'b0, 5'h09, 5'h0C, 16'h1234, 16'h0);
    rd(A_CMD, v); chk("R10 command kept", 64'(v), 64'h0100);

    // R9 turnaround error, stickiness, clear
    start(2'd2, 1'b1, 1'b1, 5'h02, 5'h01, 16'h0, 16'h7E81, 1'b1);
    wait_idle();
    rd(A_STS, v); chk("R9 error set", 64'(v), 64'h0002);
    start(2'd2, 1'b1, 1'b1, 5'h02, 5'h01, 16'h0, 16'h6666, 1'b0);
    wait_idle();
    rd(A_DAT, v); chk("R8 read after error", 64'(v), 64'h6666);
    rd(A_STS, v); chk("R9 error sticky", 64'(v), 64'h0002);
    wr(A_STS, 16'h0001);
    rd(A_STS, v); chk("R9 wrong bit keeps error", 64'(v), 64'h0002);
    wr(A_STS, 16'h0002);
    rd(A_STS, v); chk("R9 error cleared", 64'(v), 64'h0000);

    // R11 abort by hold
    start(2'd1, 1'b1, 1'b0, 5'h01, 5'h01, 16'hFFFF, 16'h0, 1'b0);
    repeat (30) @(negedge clk);
    wr(A_CTL, 16'h9000);
    @(negedge clk);
    reg_addr = A_CMD; #1;
    chk("R11 abort busy/mdc/oe", 64'({reg_rdata[15], mdc, mdio_oe}), 64'(0));
    wr(A_CTL, 16'h0000);

    // R11 MDIO select cleared
    arm(1'b0, 1'b0, 16'h0);
    wr(A_CMD, 16'h0100);
    repeat (20) @(negedge clk);
    rd(A_CMD, v); chk("R11 select low no start", 64'(v[15]), 64'(0));
    chk("R11 select low no mdc", 64'(nrise), 64'(0));
    wr(A_CTL, 16'h1000);
    start(2'd0, 1'b0, 1'b1, 5'h04, 5'h08, 16'h00AA, 16'h0, 1'b0);
    wait_idle();
    check_frame("R11 re-enabled", 2'd0, 1'b0, 1'b1, 5'h04, 5'h08, 16'h00AA, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule